// File: doc/BRIEF.md
# SMBus Host Register Model and Transaction Sequencer

This block presents an SMBus host controller to software as a small byte-addressed register space. The registers hold a protocol code, a status byte, the shifted target address, a command byte, a 32-byte data buffer, a byte count and a latched alarm (address plus a 16-bit word). Software fills the registers it needs and then writes the protocol code. That write launches a transaction.

The block decodes the protocol code and raises a one-cycle start request toward a bit-level bus engine, which is not part of this block. With the request it presents the protocol code, the PEC request, the 7-bit target, the command and the number of data bytes to send. The engine pulls transmit bytes through an index port, writes received bytes back into the data buffer, and reports completion with a 5-bit result code and a received byte count. The block records completion in the status register. For block reads it also updates the byte count.

Top module: `smb_regmodel_seq`

## Requirements
- R1: After synchronous reset, every register offset 0x00..0x27 reads 0x00 and no start request is raised.
- R2: Host writes to the address (0x02), command (0x03), data (0x04..0x23) and byte count (0x24) registers read back unchanged. The status byte (0x01) reads as {DONE, ALARM, 0, code[4:0]}.
- R3: When idle, a write of a supported code to offset 0x00 produces a one-cycle `eng_start` in the following cycle, with status 0x00. At the same time `eng_proto` carries the written code, `eng_pec` carries its bit 7, `eng_target` carries address register bits 7:1 and `eng_cmd` carries the command register.
- R4: The supported codes have low seven bits 0x02..0x0D, 0x4A or 0x4B, with bit 7 free. Bit 0 selects read, except for 0x0C and 0x0D, which always read back. Any other code gives status 0x99 (DONE, code 0x19) in the following cycle and raises no start.
- R5: An `eng_done` pulse while busy gives status DONE=1 with code = `eng_result` in the following cycle.
- R6: `eng_len` is 1 for 0x06. It is 2 for 0x08 and 0x0C. It is min(count,32) for 0x0A and for 0x4A/0x4B, and min(count,31) for 0x0D. All other codes give 0.
- R7: `eng_rx_we` writes `eng_rx_byte` into data byte `eng_rx_idx`. A word read puts the low byte at 0x04 and the high byte at 0x05. `eng_tx_byte` returns data byte `eng_tx_idx`.
- R8: Completion of a block read (0x0B) or a block process call (0x0D) loads the byte count with min(`eng_rx_cnt`,32). Completion of any other code leaves the byte count unchanged.
- R9: A write to offset 0x00 while busy is ignored. The latched code is unchanged, no start is raised, and the status shows DONE=0 with code 0x1A until the engine completes.
- R10: `alarm_valid` latches the alarm address at 0x25 and the alarm word at 0x26 (low byte) and 0x27 (high byte), and sets status bit 6. A host write to 0x01 with bit 6 set clears that bit, and a write with bit 6 clear leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Register write strobe |
| host_addr | input | HA_W | Register offset |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for `host_addr` (combinational) |
| eng_start | output | 1 | One-cycle transaction request |
| eng_proto | output | 8 | Latched protocol code |
| eng_pec | output | 1 | PEC requested |
| eng_target | output | 7 | Target device address |
| eng_cmd | output | 8 | Command byte |
| eng_len | output | LEN_W | Number of data bytes to transmit |
| eng_tx_idx | input | IDX_W | Transmit byte index |
| eng_tx_byte | output | 8 | Data byte at `eng_tx_idx` |
| eng_rx_we | input | 1 | Received byte write strobe |
| eng_rx_idx | input | IDX_W | Received byte index |
| eng_rx_byte | input | 8 | Received byte |
| eng_rx_cnt | input | 8 | Received block count, valid with `eng_done` |
| eng_done | input | 1 | Engine completion pulse |
| eng_result | input | 5 | Engine result code |
| alarm_valid | input | 1 | Alarm notification strobe |
| alarm_addr | input | 8 | Alarm source address |
| alarm_word | input | 16 | Alarm data word |

## Verification
Each wrong internal state shows up at the ports within one cycle. A protocol decoding fault shows on `eng_start` and in the status byte in the cycle right after the write to offset 0x00. A broken busy flag shows either as a second start request or as a missing 0x1A code after a rejected write. Length and clamp faults show directly on `eng_len` while the start is raised, or in the byte count read back after completion. The bench therefore sweeps all 256 protocol codes and a range of byte counts and received counts that runs past both clamp points, and computes every expected value from the requirement text.

// File: rtl/smb_rm_pkg.sv
package smb_rm_pkg;

    localparam int OFS_PROTO = 0;
    localparam int OFS_STAT  = 1;
    localparam int OFS_ADDR  = 2;
    localparam int OFS_CMD   = 3;
    localparam int OFS_DATA  = 4;

    localparam logic [4:0] RC_OK    = 5'h00;
    localparam logic [4:0] RC_UNSUP = 5'h19;
    localparam logic [4:0] RC_BUSY  = 5'h1A;

    typedef enum logic [3:0] {
        K_NONE, K_QUICK, K_BYTE, K_BYTE_DATA, K_WORD,
        K_BLOCK, K_PCALL, K_BPCALL, K_I2CBLK
    } kind_e;

    typedef struct packed {
        kind_e kind;
        logic  rd;
        logic  pec;
    } proto_t;

    typedef struct packed {
        logic       done;
        logic       alarm;
        logic [4:0] code;
    } status_t;

    function automatic proto_t decode(input logic [7:0] c);
        proto_t p;
        p.pec = c[7];
        p.rd  = c[0];
        case (c[6:0])
            7'h02, 7'h03: p.kind = K_QUICK;
            7'h04, 7'h05: p.kind = K_BYTE;
            7'h06, 7'h07: p.kind = K_BYTE_DATA;
            7'h08, 7'h09: p.kind = K_WORD;
            7'h0A, 7'h0B: p.kind = K_BLOCK;
            7'h0C:        begin p.kind = K_PCALL;  p.rd = 1'b1; end
            7'h0D:        begin p.kind = K_BPCALL; p.rd = 1'b1; end
            7'h4A, 7'h4B: p.kind = K_I2CBLK;
            default:      p.kind = K_NONE;
        endcase
        return p;
    endfunction

    function automatic logic [7:0] clamp(input logic [7:0] v, input int lim);
        return (int'(v) > lim) ? 8'(lim) : v;
    endfunction

    function automatic logic [7:0] tx_len(input proto_t p, input logic [7:0] cnt,
                                          input int maxb);
        case (p.kind)
            K_BYTE_DATA: return p.rd ? 8'd0 : 8'd1;
            K_WORD:      return p.rd ? 8'd0 : 8'd2;
            K_PCALL:     return 8'd2;
            K_BLOCK:     return p.rd ? 8'd0 : clamp(cnt, maxb);
            K_BPCALL:    return clamp(cnt, maxb - 1);
            K_I2CBLK:    return clamp(cnt, maxb);
            default:     return 8'd0;
        endcase
    endfunction

endpackage

// File: rtl/smb_rm_ctrl.sv
module smb_rm_ctrl
    import smb_rm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       proto_wr,
    input  logic [7:0] wdata,
    input  logic       alarm_set,
    input  logic       alarm_clr,
    input  logic       eng_done,
    input  logic [4:0] eng_result,
    output logic [7:0] proto_q,
    output logic       busy,
    output logic       start,
    output status_t    stat
);

    proto_t wr_dec;
    assign wr_dec = decode(wdata);

    always_ff @(posedge clk) begin
        if (rst) begin
            proto_q <= '0;
            busy    <= 1'b0;
            start   <= 1'b0;
            stat    <= '0;
        end else begin
            start <= 1'b0;
            if (alarm_set)      stat.alarm <= 1'b1;
            else if (alarm_clr) stat.alarm <= 1'b0;
            if (busy) begin
                if (eng_done) begin
                    busy      <= 1'b0;
                    stat.done <= 1'b1;
                    stat.code <= eng_result;
                end else if (proto_wr) begin
                    stat.code <= RC_BUSY;
                end
            end else if (proto_wr) begin
                proto_q <= wdata;
                if (wr_dec.kind == K_NONE) begin
                    stat.done <= 1'b1;
                    stat.code <= RC_UNSUP;
                end else begin
                    stat.done <= 1'b0;
                    stat.code <= RC_OK;
                    busy      <= 1'b1;
                    start     <= 1'b1;
                end
            end
        end
    end

    AST_UNSUP_FLAGGED: assert property (@(posedge clk) disable iff (rst)
        (proto_wr && !busy && wr_dec.kind == K_NONE) |=>
        (stat.done && stat.code == RC_UNSUP && !start)); // R4

    AST_BUSY_HIT: assert property (@(posedge clk) disable iff (rst)
        (busy && !eng_done && proto_wr) |=>
        (!stat.done && stat.code == RC_BUSY && !start && $stable(proto_q))); // R9

    AST_DONE_ON_CPLT: assert property (@(posedge clk) disable iff (rst)
        (busy && eng_done) |=>
        (stat.done && !busy && stat.code == $past(eng_result))); // R5

    AST_START_PULSE: assert property (@(posedge clk) disable iff (rst)
        start |-> (busy && !stat.done)); // R3

endmodule

// File: rtl/smb_rm_regs.sv
module smb_rm_regs
    import smb_rm_pkg::*;
#(
    parameter int N_DATA = 32,
    parameter int HA_W   = 6,
    parameter int IDX_W  = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             host_wr,
    input  logic [HA_W-1:0]  host_addr,
    input  logic [7:0]       host_wdata,
    output logic [7:0]       host_rdata,
    input  logic [7:0]       proto_q,
    input  status_t          stat,
    input  logic [IDX_W-1:0] tx_idx,
    output logic [7:0]       tx_byte,
    input  logic             rx_we,
    input  logic [IDX_W-1:0] rx_idx,
    input  logic [7:0]       rx_byte,
    input  logic             bcnt_ld,
    input  logic [7:0]       bcnt_val,
    input  logic             alarm_set,
    input  logic [7:0]       alarm_addr,
    input  logic [15:0]      alarm_word,
    output logic [7:0]       addr_q,
    output logic [7:0]       cmd_q,
    output logic [7:0]       bcnt_q
);

    localparam logic [HA_W-1:0] A_PROTO = HA_W'(OFS_PROTO);
    localparam logic [HA_W-1:0] A_STAT  = HA_W'(OFS_STAT);
    localparam logic [HA_W-1:0] A_ADDR  = HA_W'(OFS_ADDR);
    localparam logic [HA_W-1:0] A_CMD   = HA_W'(OFS_CMD);
    localparam logic [HA_W-1:0] A_DATA  = HA_W'(OFS_DATA);
    localparam logic [HA_W-1:0] A_BCNT  = HA_W'(OFS_DATA + N_DATA);
    localparam logic [HA_W-1:0] A_ALA   = HA_W'(OFS_DATA + N_DATA + 1);
    localparam logic [HA_W-1:0] A_ALD0  = HA_W'(OFS_DATA + N_DATA + 2);
    localparam logic [HA_W-1:0] A_ALD1  = HA_W'(OFS_DATA + N_DATA + 3);

    logic [N_DATA*8-1:0] data_flat;
    logic [7:0]          ala_q;
    logic [15:0]         ald_q;

    for (genvar i = 0; i < N_DATA; i++) begin : g_byte
        logic [7:0] q;
        always_ff @(posedge clk) begin
            if (rst)
                q <= '0;
            else if (rx_we && rx_idx == IDX_W'(i))
                q <= rx_byte;
            else if (host_wr && host_addr == HA_W'(OFS_DATA + i))
                q <= host_wdata;
        end
        assign data_flat[i*8 +: 8] = q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            cmd_q  <= '0;
            bcnt_q <= '0;
            ala_q  <= '0;
            ald_q  <= '0;
        end else begin
            if (host_wr && host_addr == A_ADDR) addr_q <= host_wdata;
            if (host_wr && host_addr == A_CMD)  cmd_q  <= host_wdata;
            if (bcnt_ld)
                bcnt_q <= bcnt_val;
            else if (host_wr && host_addr == A_BCNT)
                bcnt_q <= host_wdata;
            if (alarm_set) begin
                ala_q <= alarm_addr;
                ald_q <= alarm_word;
            end
        end
    end

    logic [HA_W-1:0] doff;
    assign doff    = host_addr - A_DATA;
    assign tx_byte = data_flat[tx_idx*8 +: 8];

    always_comb begin
        host_rdata = '0;
        if (host_addr == A_PROTO)      host_rdata = proto_q;
        else if (host_addr == A_STAT)  host_rdata = {stat.done, stat.alarm, 1'b0, stat.code};
        else if (host_addr == A_ADDR)  host_rdata = addr_q;
        else if (host_addr == A_CMD)   host_rdata = cmd_q;
        else if (host_addr >= A_DATA && host_addr < A_BCNT)
            host_rdata = data_flat[doff[IDX_W-1:0]*8 +: 8];
        else if (host_addr == A_BCNT)  host_rdata = bcnt_q;
        else if (host_addr == A_ALA)   host_rdata = ala_q;
        else if (host_addr == A_ALD0)  host_rdata = ald_q[7:0];
        else if (host_addr == A_ALD1)  host_rdata = ald_q[15:8];
    end

    AST_BCNT_CLAMPED: assert property (@(posedge clk) disable iff (rst)
        bcnt_ld |=> (int'(bcnt_q) <= N_DATA)); // R8

    AST_ALARM_LATCH: assert property (@(posedge clk) disable iff (rst)
        alarm_set |=> (ala_q == $past(alarm_addr) && ald_q == $past(alarm_word))); // R10

endmodule

// File: rtl/smb_regmodel_seq.sv
module smb_regmodel_seq
    import smb_rm_pkg::*;
#(
    parameter int N_DATA = 32,
    parameter int HA_W   = $clog2(N_DATA + 8),
    parameter int IDX_W  = $clog2(N_DATA),
    parameter int LEN_W  = $clog2(N_DATA + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             host_wr,
    input  logic [HA_W-1:0]  host_addr,
    input  logic [7:0]       host_wdata,
    output logic [7:0]       host_rdata,
    output logic             eng_start,
    output logic [7:0]       eng_proto,
    output logic             eng_pec,
    output logic [6:0]       eng_target,
    output logic [7:0]       eng_cmd,
    output logic [LEN_W-1:0] eng_len,
    input  logic [IDX_W-1:0] eng_tx_idx,
    output logic [7:0]       eng_tx_byte,
    input  logic             eng_rx_we,
    input  logic [IDX_W-1:0] eng_rx_idx,
    input  logic [7:0]       eng_rx_byte,
    input  logic [7:0]       eng_rx_cnt,
    input  logic             eng_done,
    input  logic [4:0]       eng_result,
    input  logic             alarm_valid,
    input  logic [7:0]       alarm_addr,
    input  logic [15:0]      alarm_word
);

    logic       proto_wr, stat_wr, busy;
    logic [7:0] proto_q, addr_q, cmd_q, bcnt_q;
    status_t    stat;
    proto_t     cur;
    logic       bcnt_ld;

    assign proto_wr = host_wr && host_addr == HA_W'(OFS_PROTO);
    assign stat_wr  = host_wr && host_addr == HA_W'(OFS_STAT);
    assign cur      = decode(proto_q);
    assign bcnt_ld  = busy && eng_done &&
                      ((cur.kind == K_BLOCK && cur.rd) || cur.kind == K_BPCALL);

    smb_rm_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .proto_wr   (proto_wr),
        .wdata      (host_wdata),
        .alarm_set  (alarm_valid),
        .alarm_clr  (stat_wr && host_wdata[6]),
        .eng_done   (eng_done),
        .eng_result (eng_result),
        .proto_q    (proto_q),
        .busy       (busy),
        .start      (eng_start),
        .stat       (stat)
    );

    smb_rm_regs #(.N_DATA(N_DATA), .HA_W(HA_W), .IDX_W(IDX_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .host_wr    (host_wr),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .proto_q    (proto_q),
        .stat       (stat),
        .tx_idx     (eng_tx_idx),
        .tx_byte    (eng_tx_byte),
        .rx_we      (eng_rx_we),
        .rx_idx     (eng_rx_idx),
        .rx_byte    (eng_rx_byte),
        .bcnt_ld    (bcnt_ld),
        .bcnt_val   (clamp(eng_rx_cnt, N_DATA)),
        .alarm_set  (alarm_valid),
        .alarm_addr (alarm_addr),
        .alarm_word (alarm_word),
        .addr_q     (addr_q),
        .cmd_q      (cmd_q),
        .bcnt_q     (bcnt_q)
    );

    assign eng_proto  = proto_q;
    assign eng_pec    = proto_q[7];
    assign eng_target = addr_q[7:1];
    assign eng_cmd    = cmd_q;
    assign eng_len    = LEN_W'(tx_len(cur, bcnt_q, N_DATA));

    AST_LEN_LIMIT: assert property (@(posedge clk) disable iff (rst)
        eng_start |-> (int'(eng_len) <= N_DATA)); // R6

    AST_START_PROTO: assert property (@(posedge clk) disable iff (rst)
        eng_start |-> (eng_pec == $past(host_wdata[7]) && $past(proto_wr))); // R3

endmodule

// File: tb/smb_regmodel_seq_tb_top.sv
module smb_regmodel_seq_tb_top;

    localparam int N = 32;
    localparam int HA_W = 6;
    localparam int IDX_W = 5;
    localparam int LEN_W = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic             host_wr = 0;
    logic [HA_W-1:0]  host_addr = '0;
    logic [7:0]       host_wdata = '0;
    logic [7:0]       host_rdata;
    logic             eng_start, eng_pec;
    logic [7:0]       eng_proto, eng_cmd, eng_tx_byte;
    logic [6:0]       eng_target;
    logic [LEN_W-1:0] eng_len;
    logic [IDX_W-1:0] eng_tx_idx = '0, eng_rx_idx = '0;
    logic             eng_rx_we = 0, eng_done = 0, alarm_valid = 0;
    logic [7:0]       eng_rx_byte = '0, eng_rx_cnt = '0, alarm_addr = '0;
    logic [4:0]       eng_result = '0;
    logic [15:0]      alarm_word = '0;

    smb_regmodel_seq dut_i (.*);

    int checks = 0, fails = 0;
    bit finished = 0;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic hw(input int a, input int d);
        @(negedge clk);
        host_wr = 1; host_addr = HA_W'(a); host_wdata = 8'(d);
        @(negedge clk);
        host_wr = 0;
        #1;
    endtask

    task automatic hr(input int a, output int d);
        host_addr = HA_W'(a);
        #1;
        d = int'(host_rdata);
    endtask

    task automatic finish_eng(input int res);
        @(negedge clk);
        eng_done = 1; eng_result = 5'(res);
        @(negedge clk);
        eng_done = 0;
        #1;
    endtask

    function automatic bit exp_valid(input int c);
        int l = c & 127;
        return (l >= 2 && l <= 13) || l == 74 || l == 75;
    endfunction

    function automatic int exp_len(input int c, input int b);
        int l = c & 127;
        int m32 = (b > 32) ? 32 : b;
        int m31 = (b > 31) ? 31 : b;
        if (l == 6) return 1;
        if (l == 8 || l == 12) return 2;
        if (l == 10 || l == 74 || l == 75) return m32;
        if (l == 13) return m31;
        return 0;
    endfunction

    initial begin
        int v;
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        // R1 reset state
        for (int a = 0; a < 40; a++) begin
            hr(a, v);
            chk($sformatf("R1 reg 0x%0h", a), v, 0);
        end
        chk("R1 start idle", int'(eng_start), 0);

        // R2 register readback and tx port (R7)
        hw(2, 8'h54);
        hw(3, 8'hA5);
        for (int i = 0; i < N; i++) hw(4 + i, (i * 7 + 3) & 255);
        hw(8'h24, 20);
        hr(2, v); chk("R2 address", v, 8'h54);
        hr(3, v); chk("R2 command", v, 8'hA5);
        hr(8'h24, v); chk("R2 count", v, 20);
        for (int i = 0; i < N; i++) begin
            hr(4 + i, v); chk("R2 data", v, (i * 7 + 3) & 255);
            eng_tx_idx = IDX_W'(i); #1;
            chk("R7 tx byte", int'(eng_tx_byte), (i * 7 + 3) & 255);
        end

        // R3/R4/R5 exhaustive protocol sweep
        eng_rx_cnt = 20;
        for (int c = 0; c < 256; c++) begin
            hw(0, c);
            hr(1, v);
            if (exp_valid(c)) begin
                int res = (c * 7 + 3) & 31;
                chk("R3 start", int'(eng_start), 1);
                chk("R3 status clear", v, 0);
                chk("R3 proto", int'(eng_proto), c);
                chk("R3 pec", int'(eng_pec), (c >> 7) & 1);
                chk("R3 target", int'(eng_target), 8'h2A);
                chk("R3 cmd", int'(eng_cmd), 8'hA5);
                chk("R6 len sweep", int'(eng_len), exp_len(c, 20));
                @(negedge clk); #1;
                chk("R3 start one cycle", int'(eng_start), 0);
                finish_eng(res);
                hr(1, v);
                chk("R5 status done", v, 8'h80 | res);
            end else begin
                chk("R4 no start", int'(eng_start), 0);
                chk("R4 unsupported", v, 8'h99);
            end
        end

        // R6 length clamps
        for (int b = 0; b <= 40; b++) begin
            int codes [5] = '{8'h0A, 8'h4A, 8'h4B, 8'h0D, 8'h8A};
            foreach (codes[k]) begin
                hw(8'h24, b);
                eng_rx_cnt = 8'(b);
                hw(0, codes[k]);
                chk($sformatf("R6 len code 0x%0h cnt %0d", codes[k], b),
                    int'(eng_len), exp_len(codes[k], b));
                finish_eng(0);
            end
        end

        // R8 block read count clamp
        for (int r = 0; r <= 41; r++) begin
            int rc = (r == 41) ? 255 : r;
            hw(8'h24, 9);
            eng_rx_cnt = 8'(rc);
            hw(0, (r & 1) ? 8'h0D : 8'h0B);
            finish_eng(0);
            hr(8'h24, v);
            chk("R8 count load", v, rc > 32 ? 32 : rc);
        end
        hw(8'h24, 5);
        eng_rx_cnt = 40;
        hw(0, 8'h07);
        finish_eng(0);
        hr(8'h24, v);
        chk("R8 non-block keeps count", v, 5);

        // R7 word read little-endian
        hw(0, 8'h09);
        @(negedge clk);
        eng_rx_we = 1; eng_rx_idx = 0; eng_rx_byte = 8'h34;
        @(negedge clk);
        eng_rx_idx = 1; eng_rx_byte = 8'h12;
        @(negedge clk);
        eng_rx_we = 0;
        finish_eng(0);
        hr(4, v); chk("R7 word low", v, 8'h34);
        hr(5, v); chk("R7 word high", v, 8'h12);

        // R9 write while busy
        hw(0, 8'h08);
        hw(0, 8'h02);
        hr(1, v);
        chk("R9 busy code", v, 8'h1A);
        chk("R9 no restart", int'(eng_start), 0);
        chk("R9 proto kept", int'(eng_proto), 8'h08);
        hr(0, v); chk("R9 proto reg", v, 8'h08);
        finish_eng(0);
        hr(1, v);
        chk("R9 completion after busy", v, 8'h80);

        // R10 alarm
        @(negedge clk);
        alarm_valid = 1; alarm_addr = 8'h10; alarm_word = 16'hBEEF;
        @(negedge clk);
        alarm_valid = 0;
        #1;
        hr(1, v); chk("R10 alarm flag", v & 8'h40, 8'h40);
        hr(8'h25, v); chk("R10 alarm addr", v, 8'h10);
        hr(8'h26, v); chk("R10 alarm low", v, 8'hEF);
        hr(8'h27, v); chk("R10 alarm high", v, 8'hBE);
        hw(1, 8'h00);
        hr(1, v); chk("R10 alarm kept", v & 8'h40, 8'h40);
        hw(1, 8'h40);
        hr(1, v); chk("R10 alarm cleared", v & 8'h40, 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule